// File: doc/BRIEF.md
# Flash row programming sequencer

This block runs the programming sequence for one row of an embedded flash array. A one-cycle `start` pulse carries an address inside the target row. The block first checks that the address lies inside the flash window and outside the write-protected region. It then raises the program-enable line and issues a dummy row-select strobe. After the setup wait it raises the high-voltage enable. Data bytes then arrive on a valid/ready stream. Each accepted byte becomes one write strobe to the array, followed by a minimum hold time. After the last byte the block releases program-enable, waits, releases high-voltage enable, waits out the recovery time, and returns to idle.

Every wait is a parameter in nanoseconds. The block converts each one to clock cycles from `CLK_HZ`: minimum waits round up and maximum limits round down. Two upper limits guard the array. The first is the longest gap allowed between byte strobes. The second is the total time high voltage may stay on. Breaking either limit ends the sequence through the normal release order and raises an error. Read requests to the array are held off while the block is busy.

The byte stream follows valid/ready rules. A byte transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block can take the next byte. The source must hold its byte stable while `in_valid` is high and `in_ready` is low. A byte that is presented too late is not waited for: the block aborts the sequence.

Top module: `flash_row_prog`

## Requirements
- R1: After reset `busy`, `done`, `err`, `in_ready`, `fl_pgm`, `fl_hven` and `fl_wr` are low and `err_code` is 0.
- R2: A `start` whose address is outside [FLASH_BASE, FLASH_BASE+FLASH_BYTES) sets `err_code` to 1 on the next cycle. `fl_pgm` is never raised and the block stays idle.
- R3: A `start` whose address is at or above `protect_base` sets `err_code` to 2. `fl_pgm` is never raised.
- R4: For an accepted `start`, `fl_pgm` rises 1 cycle later and `busy` rises with it. One cycle after that, a single `fl_wr` strobe appears with `fl_addr` equal to the start address and `fl_data` equal to 0.
- R5: `fl_hven` rises exactly NVS cycles after the row-select strobe, where NVS = ceil(T_NVS_NS·CLK_HZ/1e9).
- R6: `in_ready` first rises exactly PGS cycles after `fl_hven` rises, where PGS is the rounded-up setup wait.
- R7: A byte taken on an edge appears in the next cycle as a one-cycle `fl_wr` strobe carrying its address and data. `in_ready` then stays low for exactly PROG cycles (the rounded-up tPROG minimum), so back-to-back strobes are PROG+1 cycles apart.
- R8: After the final byte strobe, `fl_pgm` falls exactly PROG cycles later. `fl_hven` falls NVH cycles after that. RCV cycles later `busy` falls and `done` is high for exactly one cycle.
- R9: The byte taken with `in_last` high ends the row. So does the ROW_BYTES-th byte, even without `in_last`.
- R10: A byte whose address is outside the flash window or outside the selected row is not strobed. The sequence aborts with `err_code` 1: `fl_pgm` falls on the cycle after that byte is taken, the release order is kept, and `done` does not pulse.
- R11: If no byte is taken within GAP = floor(T_PROG_MAX_NS·CLK_HZ/1e9) cycles of the previous strobe (or of `in_ready` first rising), the sequence aborts with `err_code` 3. `fl_pgm` falls exactly GAP cycles after that strobe.
- R12: `fl_hven` is never high for more than HVMAX = floor(T_HV_MAX_NS·CLK_HZ/1e9) cycles in one sequence. Reaching the limit aborts with `err_code` 4, and `fl_pgm` is released early enough that `fl_hven` falls after exactly HVMAX cycles.
- R13: `rd_gnt` equals `rd_req` while the block is idle and is 0 while `busy` is high.
- R14: `err` and `err_code` hold their value until the next accepted `start`. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a row sequence (taken only when idle) |
| start_addr | input | ADDR_W | Any address in the target row |
| protect_base | input | ADDR_W | Addresses at or above this are write-protected |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_addr | input | ADDR_W | Byte target address |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Marks the final byte of the row |
| fl_pgm | output | 1 | Array program-enable |
| fl_hven | output | 1 | Array high-voltage enable |
| fl_wr | output | 1 | Address/data latch strobe, one cycle |
| fl_addr | output | ADDR_W | Address for the strobe |
| fl_data | output | 8 | Data for the strobe |
| rd_req | input | 1 | Normal read request to the array |
| rd_gnt | output | 1 | Read request granted |
| busy | output | 1 | Sequence in progress, including recovery |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Sticky error flag |
| err_code | output | 3 | 0 none, 1 address, 2 protected, 3 stall, 4 high-voltage limit |

## Verification
A wrong state or counter in this block shows up first as a moved edge on `fl_pgm`, `fl_hven`, `in_ready` or `busy`. The bench therefore times each edge relative to the one before it and requires the exact cycle count, which catches an off-by-one in any wait within that one sequence. A broken abort path leaves `fl_hven` high too long, skips the program-enable-first release, or sets the wrong `err_code`. Each of these is visible within a few cycles of the stall or of the bad byte. A second instance with a tight high-voltage limit runs on the same stimulus and exposes the high-voltage budget.

// File: rtl/frp_pkg.sv
package frp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROWSEL, ST_NVS, ST_PGS, ST_DATA, ST_HOLD, ST_NVH, ST_RCV
  } frp_state_e;

  typedef enum logic [2:0] {
    EC_NONE  = 3'd0,
    EC_RANGE = 3'd1,
    EC_PROT  = 3'd2,
    EC_STALL = 3'd3,
    EC_HV    = 3'd4
  } frp_err_e;

  // minimum waits: round up so the array never sees a short interval
  function automatic longint cyc_ceil(longint ns, longint hz);
    return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

  // maximum limits: round down so the limit is never overshot
  function automatic longint cyc_floor(longint ns, longint hz);
    return (ns * hz) / 64'd1_000_000_000;
  endfunction

  function automatic longint max2(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/frp_wait_timer.sv
module frp_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_WAIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("wait timer skipped"); // R5
endmodule

// File: rtl/frp_gap_timer.sv
module frp_gap_timer #(
  parameter int GAP_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int GW = $clog2(GAP_CYC + 1);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 gap_q <= '0;
    else if (restart)                           gap_q <= '0;
    else if (run && gap_q < GW'(GAP_CYC))       gap_q <= gap_q + 1'b1;
  end

  assign expired = (gap_q >= GW'(GAP_CYC - 1));

  AST_GAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (gap_q < GW'(GAP_CYC))) else $error("byte gap overran"); // R11
endmodule

// File: rtl/frp_hv_meter.sv
module frp_hv_meter #(
  parameter int HV_CYC  = 1000,
  parameter int LIM_CYC = 990
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hv_on,
  output logic over
);
  localparam int HW = $clog2(HV_CYC + 1);
  logic [HW-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 acc_q <= '0;
    else if (clear)                             acc_q <= '0;
    else if (hv_on && acc_q < HW'(HV_CYC))      acc_q <= acc_q + 1'b1;
  end

  assign over = (acc_q >= HW'(LIM_CYC));

  AST_HV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hv_on |-> (acc_q < HW'(HV_CYC))) else $error("high voltage over budget"); // R12
endmodule

// File: rtl/flash_row_prog.sv
module flash_row_prog
  import frp_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int ADDR_W        = 16,
  parameter int FLASH_BASE    = 'h4000,
  parameter int FLASH_BYTES   = 'h8000,
  parameter int ROW_BYTES     = 64,
  parameter int T_NVS_NS      = 10_000,
  parameter int T_PGS_NS      = 5_000,
  parameter int T_PROG_NS     = 30_000,
  parameter int T_PROG_MAX_NS = 40_000,
  parameter int T_NVH_NS      = 5_000,
  parameter int T_RCV_NS      = 1_000,
  parameter int T_HV_MAX_NS   = 4_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] protect_base,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              fl_pgm,
  output logic              fl_hven,
  output logic              fl_wr,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_data,
  input  logic              rd_req,
  output logic              rd_gnt,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code
);
  localparam int NVS_CYC  = int'(cyc_ceil(T_NVS_NS, CLK_HZ));
  localparam int PGS_CYC  = int'(cyc_ceil(T_PGS_NS, CLK_HZ));
  localparam int PROG_CYC = int'(cyc_ceil(T_PROG_NS, CLK_HZ));
  localparam int NVH_CYC  = int'(cyc_ceil(T_NVH_NS, CLK_HZ));
  localparam int RCV_CYC  = int'(cyc_ceil(T_RCV_NS, CLK_HZ));
  localparam int GAP_CYC  = int'(cyc_floor(T_PROG_MAX_NS, CLK_HZ));
  localparam int HV_CYC   = int'(cyc_floor(T_HV_MAX_NS, CLK_HZ));
  localparam int HV_LIM   = HV_CYC - NVH_CYC - 1;
  localparam int MAX_WAIT = int'(max2(max2(max2(NVS_CYC, PGS_CYC), max2(PROG_CYC, NVH_CYC)), RCV_CYC));
  localparam int TW       = $clog2(MAX_WAIT + 1);
  localparam int ROW_LG   = $clog2(ROW_BYTES);
  localparam int CW       = $clog2(ROW_BYTES + 1);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(FLASH_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(FLASH_BASE + FLASH_BYTES);

  frp_state_e        st_q, st_n;
  frp_err_e          ec_q, ec_n;
  logic              pgm_q, pgm_n, hv_q, hv_n, wr_n, done_n;
  logic [ADDR_W-1:0] row_q, row_n, fa_q, fa_n;
  logic [7:0]        fd_q, fd_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              last_q, last_n, wr_q, done_q;
  logic              t_load, t_exp, gap_exp, hv_over, accept;
  logic [TW-1:0]     t_val;
  logic              start_in_win, byte_in_win, byte_in_row, byte_ok;

  assign start_in_win = ({1'b0, start_addr} >= WIN_LO) && ({1'b0, start_addr} < WIN_HI);
  assign byte_in_win  = ({1'b0, in_addr} >= WIN_LO) && ({1'b0, in_addr} < WIN_HI);
  assign byte_in_row  = (in_addr[ADDR_W-1:ROW_LG] == row_q[ADDR_W-1:ROW_LG]);
  assign byte_ok      = byte_in_win && byte_in_row;

  assign in_ready = (st_q == ST_DATA) && !hv_over;
  assign accept   = in_valid && in_ready;

  frp_wait_timer #(.W(TW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp));

  frp_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .restart((st_q == ST_PGS && t_exp) || accept),
    .run(st_q == ST_DATA || st_q == ST_HOLD),
    .expired(gap_exp));

  frp_hv_meter #(.HV_CYC(HV_CYC), .LIM_CYC(HV_LIM)) u_hv (
    .clk(clk), .rst_n(rst_n), .clear(st_q == ST_IDLE), .hv_on(hv_q), .over(hv_over));

  always_comb begin
    st_n = st_q;  ec_n = ec_q;  pgm_n = pgm_q;  hv_n = hv_q;
    wr_n = 1'b0;  done_n = 1'b0;
    row_n = row_q;  fa_n = fa_q;  fd_n = fd_q;  cnt_n = cnt_q;  last_n = last_q;
    t_load = 1'b0;  t_val = '0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (!start_in_win)                ec_n = EC_RANGE;
        else if (start_addr >= protect_base) ec_n = EC_PROT;
        else begin
          ec_n = EC_NONE;  pgm_n = 1'b1;  row_n = start_addr;
          cnt_n = '0;  last_n = 1'b0;  st_n = ST_ROWSEL;
        end
      end
      ST_ROWSEL: begin
        wr_n = 1'b1;  fa_n = row_q;  fd_n = 8'h00;
        t_load = 1'b1;  t_val = TW'(NVS_CYC - 1);  st_n = ST_NVS;
      end
      ST_NVS: if (t_exp) begin
        hv_n = 1'b1;  t_load = 1'b1;  t_val = TW'(PGS_CYC - 1);  st_n = ST_PGS;
      end
      ST_PGS: if (t_exp) st_n = ST_DATA;
      ST_DATA: begin
        if (hv_over) begin
          ec_n = EC_HV;  pgm_n = 1'b0;  st_n = ST_NVH;
          t_load = 1'b1;  t_val = TW'(NVH_CYC - 1);
        end else if (accept && !byte_ok) begin
          ec_n = EC_RANGE;  pgm_n = 1'b0;  st_n = ST_NVH;
          t_load = 1'b1;  t_val = TW'(NVH_CYC - 1);
        end else if (accept) begin
          wr_n = 1'b1;  fa_n = in_addr;  fd_n = in_data;
          cnt_n = cnt_q + 1'b1;
          last_n = in_last || (cnt_q == CW'(ROW_BYTES - 1));
          t_load = 1'b1;  t_val = TW'(PROG_CYC - 1);  st_n = ST_HOLD;
        end else if (gap_exp) begin
          ec_n = EC_STALL;  pgm_n = 1'b0;  st_n = ST_NVH;
          t_load = 1'b1;  t_val = TW'(NVH_CYC - 1);
        end
      end
      ST_HOLD: begin
        if (hv_over) begin
          ec_n = EC_HV;  pgm_n = 1'b0;  st_n = ST_NVH;
          t_load = 1'b1;  t_val = TW'(NVH_CYC - 1);
        end else if (t_exp && last_q) begin
          pgm_n = 1'b0;  st_n = ST_NVH;
          t_load = 1'b1;  t_val = TW'(NVH_CYC - 1);
        end else if (t_exp) begin
          st_n = ST_DATA;
        end
      end
      ST_NVH: if (t_exp) begin
        hv_n = 1'b0;  t_load = 1'b1;  t_val = TW'(RCV_CYC - 1);  st_n = ST_RCV;
      end
      ST_RCV: if (t_exp) begin
        st_n = ST_IDLE;  done_n = (ec_q == EC_NONE);
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ec_q <= EC_NONE;  pgm_q <= 1'b0;  hv_q <= 1'b0;
      wr_q <= 1'b0;  done_q <= 1'b0;  row_q <= '0;  fa_q <= '0;  fd_q <= '0;
      cnt_q <= '0;  last_q <= 1'b0;
    end else begin
      st_q <= st_n;  ec_q <= ec_n;  pgm_q <= pgm_n;  hv_q <= hv_n;
      wr_q <= wr_n;  done_q <= done_n;  row_q <= row_n;  fa_q <= fa_n;  fd_q <= fd_n;
      cnt_q <= cnt_n;  last_q <= last_n;
    end
  end

  assign fl_pgm   = pgm_q;
  assign fl_hven  = hv_q;
  assign fl_wr    = wr_q;
  assign fl_addr  = fa_q;
  assign fl_data  = fd_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign err_code = ec_q;
  assign err      = (ec_q != EC_NONE);
  assign rd_gnt   = rd_req && !busy;

  AST_STROBE_UNDER_PGM: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr |-> fl_pgm) else $error("strobe without program enable"); // R7
  AST_HV_AFTER_PGM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_hven) |-> fl_pgm) else $error("hv before program enable"); // R5
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_pgm) |-> fl_hven) else $error("hv dropped before program enable"); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fl_wr |-> (({1'b0, fl_addr} >= WIN_LO) && ({1'b0, fl_addr} < WIN_HI))) else $error("strobe outside flash"); // R10
  AST_NO_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_hven |-> !rd_gnt) else $error("read granted under high voltage"); // R13
endmodule

// File: tb/flash_row_prog_test.sv
`timescale 1ns/1ps
module flash_row_prog_test;
  localparam int E_NVS = 11, E_PGS = 5, E_PROG = 10, E_GAP = 30, E_NVH = 5, E_RCV = 3, E_HV = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0, rd_req = 1'b1;
  logic [15:0] start_addr = '0, protect_base = 16'hFFFF, in_addr = '0;
  logic [7:0]  in_data = '0;
  logic in_ready, fl_pgm, fl_hven, fl_wr, rd_gnt, busy, done, err;
  logic [15:0] fl_addr;  logic [7:0] fl_data;  logic [2:0] err_code;
  logic h_ready, h_pgm, h_hven, h_wr, h_gnt, h_busy, h_done, h_err;
  logic [15:0] h_addr;  logic [7:0] h_data;  logic [2:0] h_code;

  always #10 clk = ~clk;

  flash_row_prog #(.CLK_HZ(50_000_000), .ADDR_W(16), .FLASH_BASE('h4000), .FLASH_BYTES('h8000),
    .ROW_BYTES(64), .T_NVS_NS(210), .T_PGS_NS(100), .T_PROG_NS(190), .T_PROG_MAX_NS(610),
    .T_NVH_NS(100), .T_RCV_NS(60), .T_HV_MAX_NS(2_000_000)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .protect_base(protect_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data), .in_last(in_last),
    .fl_pgm(fl_pgm), .fl_hven(fl_hven), .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_data(fl_data),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .busy(busy), .done(done), .err(err), .err_code(err_code));

  flash_row_prog #(.CLK_HZ(50_000_000), .ADDR_W(16), .FLASH_BASE('h4000), .FLASH_BYTES('h8000),
    .ROW_BYTES(64), .T_NVS_NS(210), .T_PGS_NS(100), .T_PROG_NS(190), .T_PROG_MAX_NS(610),
    .T_NVH_NS(100), .T_RCV_NS(60), .T_HV_MAX_NS(810)) uut_hv (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .protect_base(protect_base),
    .in_valid(in_valid), .in_ready(h_ready), .in_addr(in_addr), .in_data(in_data), .in_last(in_last),
    .fl_pgm(h_pgm), .fl_hven(h_hven), .fl_wr(h_wr), .fl_addr(h_addr), .fl_data(h_data),
    .rd_req(rd_req), .rd_gnt(h_gnt), .busy(h_busy), .done(h_done), .err(h_err), .err_code(h_code));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, t_start, t_acc, t_pgm_up, t_pgm_dn, t_hv_up, t_hv_dn, t_rdy1, t_done, t_busy_dn;
  int h_up, h_dn, n_pgm_up = 0, n_done = 0, gnt_bad = 0, wn = 0;
  bit rdy_seen = 0;
  logic [15:0] wa [0:127];  logic [7:0] wd [0:127];  int wt [0:127];
  logic p_pgm = 0, p_hv = 0, p_rdy = 0, p_busy = 0, p_h = 0;

  // event recorder: values seen at a rising edge belong to the cycle that just ended
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (start) t_start = cyc;
    if (in_valid && in_ready) t_acc = cyc;
    if (fl_pgm && !p_pgm) begin t_pgm_up = cyc; n_pgm_up++; end
    if (!fl_pgm && p_pgm) t_pgm_dn = cyc;
    if (fl_hven && !p_hv) t_hv_up = cyc;
    if (!fl_hven && p_hv) t_hv_dn = cyc;
    if (in_ready && !p_rdy && !rdy_seen) begin t_rdy1 = cyc; rdy_seen = 1; end
    if (!busy && p_busy) t_busy_dn = cyc;
    if (h_hven && !p_h) h_up = cyc;
    if (!h_hven && p_h) h_dn = cyc;
    if (done) begin t_done = cyc; n_done++; end
    if (fl_wr && wn < 128) begin wa[wn] = fl_addr; wd[wn] = fl_data; wt[wn] = cyc; wn++; end
    if (rst_n && (busy ? rd_gnt : (rd_gnt != rd_req))) gnt_bad++;
    p_pgm = fl_pgm; p_hv = fl_hven; p_rdy = in_ready; p_busy = busy; p_h = h_hven;
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic go(logic [15:0] a);
    wn = 0; rdy_seen = 0;
    start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(logic [15:0] a, logic [7:0] d, logic l);
    int lim = 0;
    in_valid = 1'b1; in_addr = a; in_data = d; in_last = l;
    while (!in_ready && lim < 300) begin @(negedge clk); lim++; end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_idle();
    int lim = 0;
    while (busy && lim < 3000) begin @(negedge clk); lim++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);        chk("R1 done", done, 0);
    chk("R1 err", err, 0);          chk("R1 err_code", err_code, 0);
    chk("R1 in_ready", in_ready, 0); chk("R1 fl_pgm", fl_pgm, 0);
    chk("R1 fl_hven", fl_hven, 0);  chk("R1 fl_wr", fl_wr, 0);
  endtask

  task automatic t_bad_start();
    int ups = n_pgm_up;
    go(16'h3FC0); @(negedge clk);
    chk("R2 low addr code", err_code, 1); chk("R2 idle", busy, 0);
    go(16'hC000); @(negedge clk);
    chk("R2 high addr code", err_code, 1);
    protect_base = 16'h9000;
    go(16'hA010); @(negedge clk);
    chk("R3 protected code", err_code, 2); chk("R3 err flag", err, 1);
    protect_base = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R2 R3 no program enable", n_pgm_up - ups, 0);
  endtask

  task automatic t_full_row();
    int dn = n_done, mis = 0, spc = 0;
    go(16'h4040);
    for (int i = 0; i < 64; i++) send(16'h4040 + 16'(i), 8'(i) ^ 8'h5A, 1'b0);
    wait_idle();
    chk("R4 pgm rise", t_pgm_up - t_start, 1);
    chk("R4 rowsel time", wt[0] - t_start, 2);
    chk("R4 rowsel addr", wa[0], 16'h4040);
    chk("R4 rowsel data", wd[0], 0);
    chk("R5 nvs wait", t_hv_up - wt[0], E_NVS);
    chk("R6 pgs wait", t_rdy1 - t_hv_up, E_PGS);
    for (int i = 1; i <= 64; i++) begin
      if (wa[i] != 16'h4040 + 16'(i - 1) || wd[i] != (8'(i - 1) ^ 8'h5A)) mis++;
      if (wt[i] - wt[i-1] != E_PROG + 1 && i > 1) spc++;
    end
    chk("R7 byte content mismatches", mis, 0);
    chk("R7 strobe spacing errors", spc, 0);
    chk("R9 strobes for full row", wn, 65);
    chk("R8 pgm release", t_pgm_dn - wt[64], E_PROG);
    chk("R8 nvh wait", t_hv_dn - t_pgm_dn, E_NVH);
    chk("R8 rcv wait", t_done - t_hv_dn, E_RCV);
    chk("R8 busy with done", t_busy_dn, t_done);
    chk("R8 one done pulse", n_done - dn, 1);
    chk("R8 no error", err, 0);
  endtask

  task automatic t_last_and_ignore();
    int dn = n_done;
    go(16'h5010);
    send(16'h5010, 8'hA1, 1'b0);
    start = 1'b1; start_addr = 16'h0000; @(negedge clk); start = 1'b0;
    send(16'h5011, 8'hB2, 1'b0);
    send(16'h5012, 8'hC3, 1'b1);
    wait_idle();
    chk("R9 strobes with last", wn, 4);
    chk("R9 last byte data", wd[3], 8'hC3);
    chk("R8 release after last", t_pgm_dn - wt[3], E_PROG);
    chk("R14 busy start ignored", err_code, 0);
    chk("R9 done after last", n_done - dn, 1);
    chk("R13 read gate violations", gnt_bad, 0);
  endtask

  task automatic t_bad_byte();
    int dn = n_done;
    go(16'h6000);
    send(16'h6000, 8'h11, 1'b0);
    send(16'h6001, 8'h22, 1'b0);
    send(16'h6040, 8'h33, 1'b0);
    wait_idle();
    chk("R10 bad byte not strobed", wn, 3);
    chk("R10 code", err_code, 1);
    chk("R10 abort timing", t_pgm_dn - t_acc, 1);
    chk("R10 release order", t_hv_dn - t_pgm_dn, E_NVH);
    chk("R10 no done", n_done - dn, 0);
  endtask

  task automatic t_stall();
    int dn = n_done;
    go(16'h7000);
    send(16'h7000, 8'h44, 1'b0);
    wait_idle();
    chk("R11 stall abort time", t_pgm_dn - wt[1], E_GAP);
    chk("R11 code", err_code, 3);
    chk("R11 busy after rcv", t_busy_dn - t_hv_dn, E_RCV);
    chk("R11 no done", n_done - dn, 0);
    repeat (20) @(negedge clk);
    chk("R14 error held", err_code, 3);
  endtask

  task automatic t_hv_limit();
    go(16'h4080);
    for (int i = 0; i < 8; i++) send(16'h4080 + 16'(i), 8'(i), i == 7);
    wait_idle();
    chk("R12 hv window", h_dn - h_up, E_HV);
    chk("R12 code", h_code, 4);
    chk("R14 error cleared by start", err_code, 0);
  endtask

  initial begin
    #(20 * 150_000);
    n_bad++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_bad_start();
    t_full_row();
    t_last_and_ignore();
    t_bad_byte();
    t_stall();
    t_hv_limit();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule